// File: doc/BRIEF.md
# DRAM refresh interval timer

This block sets the pace of refresh for a DRAM controller. A free-running prescaler divides the bus clock by one of seven ratios. Each prescaler tick advances an 8-bit interval counter. The counter is compared with a programmable compare value. On a match at a tick, the counter returns to zero and a sticky match flag is set. If refresh is enabled and CAS-before-RAS mode is selected, the block also emits a one-cycle refresh request to the command sequencer.

Every request issued also advances a 10-bit refresh tally. When the tally runs past a selectable limit of 512 or 1024, it wraps to zero and sets a sticky overflow flag. Software reaches all state through a small word-wide register port. Power-on reset clears everything. A manual reset clears only the flags and the pending request, and leaves counting untouched. Standby freezes the counter at its current value.

Top module: `refresh_timer`

## Requirements
- R1: After power-on reset (rst_ni low) all four register words read 0 and refresh_req_o is low.
- R2: The clock-select field ctrl[2:0] stops the counter at code 0. Codes 1 to 7 advance it once every 4, 16, 64, 256, 1024, 2048 and 4096 bus cycles.
- R3: On a tick where the counter's low byte equals the compare value, the low byte clears to 0 and the match flag ctrl[3] sets. The period is therefore (compare+1) ticks.
- R4: While standby_i is high the counter holds its value and no match or request occurs.
- R5: A one-cycle mrst_i clears ctrl[3], ctrl[4] and any pending request. The counter keeps running, and the clock select, the other control bits, the compare value and the tally are unchanged.
- R6: A match produces refresh_req_o high for exactly one cycle, in the cycle after the match edge. This happens only when ctrl[5] (refresh enable) and ctrl[6] (CAS-before-RAS mode) are both 1.
- R7: The tally at address 3, bits [9:0], increases by one for each request. The increase takes effect the cycle after the pulse.
- R8: ctrl[7] selects the tally limit: 0 gives 1024 and 1 gives 512. A request that takes the tally past limit-1 wraps it to 0 and sets the overflow flag ctrl[4]. Reaching 512 with the limit set to 1024 does not set the flag.
- R9: Writing 0 to ctrl[3] or ctrl[4] clears that flag, and writing 1 has no effect. If a match and a clearing write fall in the same cycle, the flag stays set.
- R10: The register map is: address 0 control, address 1 counter word (low byte counts, high byte is plain read/write storage), address 2 compare (bits [7:0]), address 3 tally. A write to the counter word takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| mrst_i | input | 1 | Manual reset, synchronous, active high |
| standby_i | input | 1 | Standby, freezes the interval counter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from reg_addr_i |
| refresh_req_o | output | 1 | One-cycle refresh request |

## Verification
Two things can fall in the same bus cycle: a compare match setting the match flag, and a software write that clears that flag. The bench provokes this with a compare value of 0 and the fastest divider, so that a match occurs every 4 cycles. After observing one request pulse, it lands a clearing control write exactly on the edge of the next match. The flag must read 1 in that same cycle, and the request must appear again. A clearing write made while the counter is stopped must read 0, which shows that the clear itself works.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int CNT_W  = 8;
  localparam int RC_W   = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  // log2 of the prescale ratio for each clock-select code
  function automatic int div_log2(logic [2:0] sel);
    case (sel)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 10;
      3'd6: return 11;
      3'd7: return 12;
      default: return 1;
    endcase
  endfunction

  localparam int PRE_W = div_log2(3'd7);

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_CNT  = 2'd1,
    ADR_COR  = 2'd2,
    ADR_TALLY = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       lim_sel;
    logic       cbr;
    logic       ref_en;
    logic       ovf;
    logic       cmf;
    logic [2:0] cks;
  } ctrl_t;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import rt_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PW-1:0] pre_q;
  logic [7:0]    tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tap[0] = 1'b0;
  for (genvar g = 1; g < 8; g++) begin : g_tap
    localparam int L = div_log2(3'(g));
    assign tap[g] = &pre_q[L-1:0];
  end

  assign tick_o = tap[sel_i];
endmodule

// File: rtl/rt_interval.sv
module rt_interval #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         standby_i,
  input  logic [W-1:0] cor_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         adv;

  assign adv     = tick_i && !standby_i;
  assign match_o = adv && (cnt_q == cor_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (match_o) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_q + 1'b1;
  end

  a_r3_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && !wr_en_i |=> cnt_q == '0);
  a_r4_standby_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i && !wr_en_i |=> $stable(cnt_q));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i));
endmodule

// File: rtl/rt_tally.sv
module rt_tally #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         lim_sel_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST_FULL = '1;
  localparam logic [W-1:0] LAST_HALF = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last   = lim_sel_i ? LAST_HALF : LAST_FULL;
  assign wrap_o = inc_i && !wr_en_i && (cnt_q == last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (wrap_o)  cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_en_i && !wrap_o |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              standby_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              refresh_req_o
);
  localparam int HI_W = DATA_W - CNT_W;

  ctrl_t             ctrl_q;
  ctrl_t             wr_ctrl;
  logic [CNT_W-1:0]  cor_q;
  logic [HI_W-1:0]   cnt_hi_q;
  logic [CNT_W-1:0]  cnt;
  logic [RC_W-1:0]   tally;
  logic              tick, match, wrap, req_q;
  logic              we_ctrl, we_cnt, we_cor, we_tally;

  assign wr_ctrl  = ctrl_t'(reg_wdata_i[7:0]);
  assign we_ctrl  = reg_we_i && (reg_addr_i == ADR_CTRL);
  assign we_cnt   = reg_we_i && (reg_addr_i == ADR_CNT);
  assign we_cor   = reg_we_i && (reg_addr_i == ADR_COR);
  assign we_tally = reg_we_i && (reg_addr_i == ADR_TALLY);

  rt_prescaler #(.PW(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (ctrl_q.cks),
    .tick_o(tick)
  );

  rt_interval #(.W(CNT_W)) u_int (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .standby_i(standby_i),
    .cor_i    (cor_q),
    .wr_en_i  (we_cnt),
    .wr_data_i(reg_wdata_i[CNT_W-1:0]),
    .cnt_o    (cnt),
    .match_o  (match)
  );

  rt_tally #(.W(RC_W)) u_tally (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (req_q),
    .lim_sel_i(ctrl_q.lim_sel),
    .wr_en_i  (we_tally),
    .wr_data_i(reg_wdata_i[RC_W-1:0]),
    .cnt_o    (tally),
    .wrap_o   (wrap)
  );

  // control and sticky flags; an event outranks a clearing write, manual reset outranks both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (we_ctrl) begin
        ctrl_q.cks     <= wr_ctrl.cks;
        ctrl_q.ref_en  <= wr_ctrl.ref_en;
        ctrl_q.cbr     <= wr_ctrl.cbr;
        ctrl_q.lim_sel <= wr_ctrl.lim_sel;
      end
      if (mrst_i) begin
        ctrl_q.cmf <= 1'b0;
        ctrl_q.ovf <= 1'b0;
      end else begin
        ctrl_q.cmf <= match || (ctrl_q.cmf && !(we_ctrl && !wr_ctrl.cmf));
        ctrl_q.ovf <= wrap  || (ctrl_q.ovf && !(we_ctrl && !wr_ctrl.ovf));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cor_q    <= '0;
      cnt_hi_q <= '0;
      req_q    <= 1'b0;
    end else begin
      if (we_cor) cor_q    <= reg_wdata_i[CNT_W-1:0];
      if (we_cnt) cnt_hi_q <= reg_wdata_i[DATA_W-1:CNT_W];
      req_q <= match && ctrl_q.ref_en && ctrl_q.cbr && !mrst_i;
    end
  end

  assign refresh_req_o = req_q;

  always_comb begin
    unique case (reg_addr_i)
      ADR_CTRL:  reg_rdata_o = {{(DATA_W-8){1'b0}}, ctrl_q};
      ADR_CNT:   reg_rdata_o = {cnt_hi_q, cnt};
      ADR_COR:   reg_rdata_o = {{HI_W{1'b0}}, cor_q};
      default:   reg_rdata_o = {{(DATA_W-RC_W){1'b0}}, tally};
    endcase
  end

  a_r6_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |-> $past(ctrl_q.ref_en && ctrl_q.cbr));
  a_r6_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |=> !refresh_req_o);
  a_r5_mrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> !ctrl_q.cmf && !ctrl_q.ovf && !refresh_req_o);
  a_r9_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && !mrst_i |=> ctrl_q.cmf);
  a_r2_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.cks == 3'd0 && !we_cnt |=> $stable(cnt));
endmodule

// File: tb/sim_refresh_timer.sv
module sim_refresh_timer;
  logic        clk = 1'b0;
  logic        rst_n, mrst, stby, we;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        req;
  int          errs = 0, checks = 0, req_cnt = 0;
  bit          done = 0;

  typedef struct {
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  refresh_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .standby_i(stby),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .refresh_req_o(req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts pulses and retires scoreboard items
  always @(negedge clk) begin
    item_t it;
    if (req) req_cnt++;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(it.tag, int'(rdata & it.mask), int'(it.exp));
    end
  end

  function automatic logic [15:0] ctl(int cks, bit en, bit cbr, bit lim, bit keep);
    return {8'h00, lim, cbr, en, keep, keep, 3'(cks)};
  endfunction

  task automatic expect_rd(logic [1:0] a, logic [15:0] e, logic [15:0] m, string tag);
    @(posedge clk); #1;
    addr = a;
    sb_q.push_back('{e, m, tag});
    @(negedge clk); #1;
  endtask

  task automatic peek(logic [1:0] a, output int v);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk); #1;
    v = int'(rdata);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_req;
    do @(negedge clk); while (!req);
    #1;
  endtask

  task automatic rate(int cks, int win, int exp, string tag);
    int a, b;
    wr(2'd0, ctl(cks, 0, 0, 0, 1));
    peek(2'd1, a);
    repeat (win - 1) @(posedge clk);
    peek(2'd1, b);
    chk(tag, (b - a) & 8'hff, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int a, b, r0;
    rst_n = 1'b0; mrst = 1'b0; stby = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(2'd0, 16'h0, 16'hffff, "R1 ctrl");
    expect_rd(2'd1, 16'h0, 16'hffff, "R1 cnt");
    expect_rd(2'd2, 16'h0, 16'hffff, "R1 cor");
    expect_rd(2'd3, 16'h0, 16'hffff, "R1 tally");
    chk("R1 req", int'(req), 0);

    // R10 map and storage
    wr(2'd1, 16'hA55A);
    expect_rd(2'd1, 16'hA55A, 16'hffff, "R10 cnt word");
    wr(2'd2, 16'h00FF);
    expect_rd(2'd2, 16'h00FF, 16'hffff, "R10 cor");
    wr(2'd1, 16'h0000);

    // R2 divider ratios
    rate(0, 40, 0, "R2 stopped");
    rate(1, 40, 10, "R2 div4");
    rate(2, 160, 10, "R2 div16");
    wr(2'd1, 16'h0000);
    rate(7, 8192, 2, "R2 div4096");

    // R4 standby
    wr(2'd0, ctl(1, 0, 0, 0, 1));
    stby = 1'b1;
    peek(2'd1, a); repeat (39) @(posedge clk); peek(2'd1, b);
    chk("R4 standby hold", b - a, 0);
    stby = 1'b0;

    // R3 / R6 / R7 periodic match
    wr(2'd0, ctl(0, 0, 0, 0, 0));
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd0);
    wr(2'd0, ctl(1, 1, 1, 0, 1));
    @(posedge clk); #1 addr = 2'd1;
    wait_req;
    chk("R3 counter cleared at match", int'(rdata[7:0]), 0);
    addr = 2'd0;
    #1 chk("R3 match flag", int'(rdata[3]), 1);
    peek(2'd3, a); r0 = req_cnt;
    repeat (159) @(posedge clk);
    peek(2'd3, b);
    chk("R6 pulses per 160 cycles", req_cnt - r0, 10);
    chk("R7 tally step", b - a, 10);

    // R6 gating
    wr(2'd0, ctl(0, 0, 0, 0, 0));
    wr(2'd2, 16'd0);
    wr(2'd0, ctl(1, 1, 0, 0, 1));
    r0 = req_cnt;
    repeat (40) @(posedge clk);
    wr(2'd0, ctl(0, 0, 1, 0, 1));
    chk("R6 no req without cbr", req_cnt - r0, 0);
    expect_rd(2'd0, 16'h0008, 16'h0008, "R6 flag still set");
    wr(2'd0, ctl(1, 0, 1, 0, 1));
    repeat (40) @(posedge clk);
    wr(2'd0, ctl(0, 0, 1, 0, 1));
    chk("R6 no req without enable", req_cnt - r0, 0);

    // R9 clear and write-one
    wr(2'd0, ctl(0, 0, 0, 0, 0));
    expect_rd(2'd0, 16'h0000, 16'h0018, "R9 clear");
    wr(2'd0, ctl(0, 0, 0, 0, 1));
    expect_rd(2'd0, 16'h0000, 16'h0018, "R9 write one no effect");

    // R9 set vs clear in same cycle
    wr(2'd0, ctl(1, 1, 1, 0, 1));
    wait_req;
    repeat (2) @(posedge clk);
    @(posedge clk); #1;
    we = 1'b1; addr = 2'd0; wdata = ctl(1, 1, 1, 0, 0);
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk); #1;
    chk("R9 set wins over clear", int'(rdata[3]), 1);
    chk("R9 req at collision", int'(req), 1);

    // R4 no request in standby
    stby = 1'b1;
    r0 = req_cnt;
    repeat (40) @(posedge clk);
    #1 chk("R4 no req in standby", req_cnt - r0, 0);
    stby = 1'b0;

    // R5 manual reset
    wait_req;
    wr(2'd2, 16'h00FF);
    @(posedge clk); #1 mrst = 1'b1;
    @(posedge clk); #1 mrst = 1'b0;
    expect_rd(2'd0, 16'h0061, 16'hffff, "R5 ctrl after manual reset");
    expect_rd(2'd2, 16'h00FF, 16'hffff, "R5 cor kept");
    peek(2'd1, a); repeat (39) @(posedge clk); peek(2'd1, b);
    chk("R5 counter runs", b - a, 10);

    // R8 limit 512
    wr(2'd0, ctl(0, 1, 1, 1, 0));
    wr(2'd2, 16'd0);
    wr(2'd3, 16'd510);
    wr(2'd0, ctl(1, 1, 1, 1, 1));
    wait_req; wait_req;
    wr(2'd0, ctl(0, 1, 1, 1, 1));
    expect_rd(2'd3, 16'd0, 16'hffff, "R8 wrap at 512");
    expect_rd(2'd0, 16'h0010, 16'h0010, "R8 ovf at 512");

    // R8 limit 1024: 512 is no overflow, 1024 is
    wr(2'd0, ctl(0, 1, 1, 0, 0));
    wr(2'd3, 16'd511);
    wr(2'd0, ctl(1, 1, 1, 0, 1));
    wait_req;
    wr(2'd0, ctl(0, 1, 1, 0, 1));
    expect_rd(2'd3, 16'd512, 16'hffff, "R8 tally 512 under 1024");
    expect_rd(2'd0, 16'h0000, 16'h0010, "R8 no ovf under 1024");
    wr(2'd3, 16'd1023);
    wr(2'd0, ctl(1, 1, 1, 0, 1));
    wait_req;
    wr(2'd0, ctl(0, 1, 1, 0, 1));
    expect_rd(2'd3, 16'd0, 16'hffff, "R8 wrap at 1024");
    expect_rd(2'd0, 16'h0010, 16'h0010, "R8 ovf at 1024");
    expect_rd(2'd0, 16'h0000, 16'h0000, "R7 drain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule